// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzler

This unit rewrites physical byte addresses for tiled surfaces so that the channel-select bit matches what a dual-channel interleaved memory system expects. Each access carries a byte address and a tiling orientation: linear, X-tiled or Y-tiled. A configuration register holds one swizzle mode for X-tiled surfaces and a separate one for Y-tiled surfaces. A level input reports whether memory runs interleaved. The unit changes only address bit 6. That bit is replaced by the XOR of itself with a set of higher bits, and the set is chosen by the mode that applies to the access.

The result passes through a single output register with a valid/ready handshake. A result appears one cycle after its request is accepted. The unit can accept a new request in every cycle in which the downstream side is ready. Together with the address, the unit returns the tiling that was actually applied. A request whose mode cannot be handled comes back marked as linear.

Top module: `addr_swizzle_top`

## Requirements
- R1: Every output address bit other than bit 6 equals the same bit of the accepted input address.
- R2: For an X-tiled access (tile code 1), interleave high and mode code 2 ("9,10"), output bit 6 is a6 ^ a9 ^ a10.
- R3: For a Y-tiled access (tile code 2), interleave high and mode code 1 ("9"), output bit 6 is a6 ^ a9.
- R4: Mode code 4 ("9,10,11") gives a6^a9^a10^a11, and mode code 3 ("9,11") gives a6^a9^a11.
- R5: Mode code 6 ("9,10,17") gives a6^a9^a10^a17, and mode code 5 ("9,17") gives a6^a9^a17.
- R6: With the interleave input low, no address is altered for any mode. The reported tiling is the requested X or Y code.
- R7: Tile code 0 (linear) and the reserved tile code 3 are never swizzled, and both are reported as tile code 0.
- R8: Mode code 7 (unknown) for the orientation of an access gives an unaltered address reported as tile code 0. Mode code 0 (none) leaves the address unaltered.
- R9: A request is accepted when in_valid and in_ready are both high, and its result is presented with out_valid high on the next cycle. in_ready equals !out_valid || out_ready. After reset, out_valid is low.
- R10: While out_valid is high and out_ready is low, out_valid, out_addr and out_tile hold their values.
- R11: Asserting cfg_we loads cfg_x_mode and cfg_y_mode together. The new modes apply to requests accepted from the next cycle on. Both modes reset to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the mode register |
| cfg_x_mode | input | 3 | Swizzle mode for X-tiled surfaces |
| cfg_y_mode | input | 3 | Swizzle mode for Y-tiled surfaces |
| mem_interleaved | input | 1 | High when memory runs dual-channel interleaved |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | ADDR_W | Physical byte address |
| in_tile | input | 2 | Tiling: 0 linear, 1 X, 2 Y, 3 reserved |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_addr | output | ADDR_W | Swizzled address |
| out_tile | output | 2 | Tiling actually applied |

## Verification
The bench builds the unit with ADDR_W set to 24. At that width bit 17 is a live tap, so the bit-17 modes are exercised for real and not through the narrow-address variant. Bits 18 to 23 remain above every tap, so they show that upper bits pass through unchanged. Address patterns set and clear bits 9, 10, 11 and 17 one at a time and in combination, so that a tap taken from the wrong position changes the expected bit 6. A pseudo-random stall pattern on out_ready checks hold and throughput against the scoreboard.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [1:0] {
    TILE_LIN = 2'd0,
    TILE_X   = 2'd1,
    TILE_Y   = 2'd2,
    TILE_RSV = 2'd3
  } tile_e;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6,
    SWZ_UNK      = 3'd7
  } swz_e;

  localparam int NTAP = 4;

  // tap enables, index 0..3 -> address bits 9, 10, 11, 17
  typedef logic [NTAP-1:0] tap_t;

endpackage

// File: rtl/swz_cfg_reg.sv
module swz_cfg_reg
  import swz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  swz_e x_mode_i,
  input  swz_e y_mode_i,
  output swz_e x_mode_o,
  output swz_e y_mode_o
);

  swz_e x_q, y_q, x_d, y_d;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (we) begin
      x_d = x_mode_i;
      y_d = y_mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= SWZ_NONE;
      y_q <= SWZ_NONE;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x_mode_o = x_q;
  assign y_mode_o = y_q;

endmodule

// File: rtl/swz_tap_decode.sv
module swz_tap_decode
  import swz_pkg::*;
(
  input  tile_e tile_i,
  input  swz_e  x_mode_i,
  input  swz_e  y_mode_i,
  input  logic  interleaved_i,
  output tap_t  taps_o,
  output tile_e tile_o
);

  swz_e sel_mode;
  logic tiled;

  always_comb begin
    tiled    = 1'b1;
    sel_mode = SWZ_NONE;
    case (tile_i)
      TILE_X:  sel_mode = x_mode_i;
      TILE_Y:  sel_mode = y_mode_i;
      default: tiled = 1'b0;
    endcase
  end

  always_comb begin
    taps_o = '0;
    tile_o = tile_i;
    if (!tiled || sel_mode == SWZ_UNK) begin
      tile_o = TILE_LIN;
    end else if (interleaved_i) begin
      case (sel_mode)
        SWZ_9:       taps_o = 4'b0001;
        SWZ_9_10:    taps_o = 4'b0011;
        SWZ_9_11:    taps_o = 4'b0101;
        SWZ_9_10_11: taps_o = 4'b0111;
        SWZ_9_17:    taps_o = 4'b1001;
        SWZ_9_10_17: taps_o = 4'b1011;
        default:     taps_o = 4'b0000;
      endcase
    end
  end

endmodule

// File: rtl/swz_xor_core.sv
module swz_xor_core
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  tap_t              taps_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int SWZ_BIT = 6;
  localparam int TAP_POS [NTAP] = '{9, 10, 11, 17};

  logic [NTAP-1:0] term;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    if (TAP_POS[i] < ADDR_W) begin : g_live
      assign term[i] = taps_i[i] & addr_i[TAP_POS[i]];
    end else begin : g_dead
      assign term[i] = 1'b0;
    end
  end

  always_comb begin
    addr_o          = addr_i;
    addr_o[SWZ_BIT] = addr_i[SWZ_BIT] ^ (^term);
  end

endmodule

// File: rtl/swz_out_stage.sv
module swz_out_stage
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] addr_i,
  input  tile_e             tile_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] addr_o,
  output tile_e             tile_o
);

  logic              vld_q, vld_d, load;
  logic [ADDR_W-1:0] addr_q;
  tile_e             tile_q;

  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= addr_i;
      tile_q <= tile_i;
    end
  end

  assign out_valid = vld_q;
  assign addr_o    = addr_q;
  assign tile_o    = tile_q;

  // R9
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(addr_o) && $stable(tile_o)));

endmodule

// File: rtl/addr_swizzle_top.sv
module addr_swizzle_top
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_x_mode,
  input  logic [2:0]        cfg_y_mode,
  input  logic              mem_interleaved,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_tile,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_tile
);

  localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << 6);

  swz_e              x_mode, y_mode;
  tap_t              taps;
  tile_e             eff_tile, reg_tile;
  logic [ADDR_W-1:0] swz_addr;

  swz_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .x_mode_i (swz_e'(cfg_x_mode)),
    .y_mode_i (swz_e'(cfg_y_mode)),
    .x_mode_o (x_mode),
    .y_mode_o (y_mode)
  );

  swz_tap_decode u_dec (
    .tile_i        (tile_e'(in_tile)),
    .x_mode_i      (x_mode),
    .y_mode_i      (y_mode),
    .interleaved_i (mem_interleaved),
    .taps_o        (taps),
    .tile_o        (eff_tile)
  );

  swz_xor_core #(.ADDR_W(ADDR_W)) u_xor (
    .addr_i (in_addr),
    .taps_i (taps),
    .addr_o (swz_addr)
  );

  swz_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .addr_i    (swz_addr),
    .tile_i    (eff_tile),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .addr_o    (out_addr),
    .tile_o    (reg_tile)
  );

  assign out_tile = reg_tile;

  // R1
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((out_addr & KEEP_MASK) == ($past(in_addr) & KEEP_MASK)));

  // R7
  linear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_tile == 2'd0 || in_tile == 2'd3))
      |=> (out_addr == $past(in_addr) && out_tile == 2'd0));

  // R8
  unknown_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_tile == 2'd1 && x_mode == SWZ_UNK)
      |=> (out_addr == $past(in_addr) && out_tile == 2'd0));

endmodule

// File: tb/addr_swizzle_top_bench.sv
`timescale 1ns/1ps
module addr_swizzle_top_bench;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_x_mode, cfg_y_mode;
  logic          mem_interleaved;
  logic          in_valid;
  logic          in_ready;
  logic [AW-1:0] in_addr;
  logic [1:0]    in_tile;
  logic          out_valid;
  logic          out_ready;
  logic [AW-1:0] out_addr;
  logic [1:0]    out_tile;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench-side copy of the configuration, written only by cfg_load
  logic [2:0] sh_x = 3'd0, sh_y = 3'd0;

  logic [AW-1:0] exp_addr_q [$];
  logic [1:0]    exp_tile_q [$];
  string         exp_tag_q  [$];

  logic       bp_en = 1'b0;
  logic       rdy_force = 1'b1;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  addr_swizzle_top #(.ADDR_W(AW)) u_addr_swizzle_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_x_mode(cfg_x_mode),
    .cfg_y_mode(cfg_y_mode), .mem_interleaved(mem_interleaved),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_tile(in_tile), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_tile(out_tile)
  );

  always @(negedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= bp_en ? lfsr[0] : rdy_force;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input logic [AW-1:0] a, input logic [1:0] t,
                       output logic [AW-1:0] ea, output logic [1:0] et);
    logic [2:0] m;
    logic x;
    ea = a;
    et = t;
    if (t == 2'd1)      m = sh_x;
    else if (t == 2'd2) m = sh_y;
    else begin et = 2'd0; return; end
    if (m == 3'd7) begin et = 2'd0; return; end
    if (!mem_interleaved || m == 3'd0) return;
    x = a[9];
    if (m == 3'd2 || m == 3'd4 || m == 3'd6) x ^= a[10];
    if (m == 3'd3 || m == 3'd4) x ^= a[11];
    if (m == 3'd5 || m == 3'd6) x ^= a[17];
    ea[6] = a[6] ^ x;
  endtask

  task automatic send(string tag, logic [AW-1:0] a, logic [1:0] t);
    logic [AW-1:0] ea;
    logic [1:0] et;
    bit ok;
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    in_tile  = t;
    forever begin
      #1;
      ok = in_ready;
      if (ok) begin
        model(a, t, ea, et);
        exp_addr_q.push_back(ea);
        exp_tile_q.push_back(et);
        exp_tag_q.push_back(tag);
      end
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic cfg_load(logic [2:0] xm, logic [2:0] ym);
    @(negedge clk);
    cfg_we = 1'b1; cfg_x_mode = xm; cfg_y_mode = ym;
    @(negedge clk);
    cfg_we = 1'b0;
    sh_x = xm; sh_y = ym;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_addr_q.size() != 0; i++) @(negedge clk);
    check("drain", exp_addr_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (exp_addr_q.size() == 0) begin
        check("R9_unexpected_output", 1, 0);
      end else begin
        string tg;
        logic [AW-1:0] ea;
        logic [1:0] et;
        tg = exp_tag_q.pop_front();
        ea = exp_addr_q.pop_front();
        et = exp_tile_q.pop_front();
        check(tg, {6'd0, out_tile, out_addr}, {6'd0, et, ea});
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_x_mode = '0; cfg_y_mode = '0;
    mem_interleaved = 1'b1; in_valid = 1'b0; in_addr = '0; in_tile = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R9: reset state
    check("R9_reset_out_valid", out_valid, 0);
    check("R9_reset_in_ready", in_ready, 1);

    // R11: reset modes are code 0, no swizzle even when interleaved
    send("R11_reset_mode_x", 24'h000240, 2'd1);
    send("R11_reset_mode_y", 24'h000200, 2'd2);
    drain();

    cfg_load(3'd2, 3'd1);
    // R2 X with 9,10
    send("R2_x_bit9", 24'h000200, 2'd1);
    send("R2_x_bit10", 24'h000400, 2'd1);
    send("R2_x_both", 24'h000600, 2'd1);
    send("R2_x_b6_b9", 24'h000240, 2'd1);
    // R3 Y with 9 only
    send("R3_y_bit9", 24'h000200, 2'd2);
    send("R3_y_bit10_ignored", 24'h000400, 2'd2);
    // R1 upper bits pass
    send("R1_all_ones_x", 24'hFFFFFF, 2'd1);
    send("R1_pattern_y", 24'hA5C3BF, 2'd2);
    // R7 linear and reserved
    send("R7_linear", 24'h000600, 2'd0);
    send("R7_reserved", 24'h000E40, 2'd3);
    drain();

    cfg_load(3'd4, 3'd3);
    // R4 bit 11 modes
    send("R4_x_b11", 24'h000800, 2'd1);
    send("R4_x_b9_10_11", 24'h000E00, 2'd1);
    send("R4_y_b11", 24'h000800, 2'd2);
    send("R4_y_b10_b11", 24'h000C40, 2'd2);
    send("R4_x_b17_ignored", 24'h020000, 2'd1);
    drain();

    cfg_load(3'd6, 3'd5);
    // R5 bit 17 modes
    send("R5_x_b17", 24'h020000, 2'd1);
    send("R5_x_b17_b10", 24'h020400, 2'd1);
    send("R5_y_b17", 24'h020040, 2'd2);
    send("R5_y_b11_ignored", 24'h000800, 2'd2);
    drain();

    // R6 not interleaved
    @(negedge clk); mem_interleaved = 1'b0;
    send("R6_x_noilv", 24'h020E00, 2'd1);
    send("R6_y_noilv", 24'h020E40, 2'd2);
    drain();
    @(negedge clk); mem_interleaved = 1'b1;

    // R8 unknown and none
    cfg_load(3'd7, 3'd1);
    send("R8_x_unknown", 24'h000640, 2'd1);
    send("R8_y_still_works", 24'h000200, 2'd2);
    cfg_load(3'd0, 3'd7);
    send("R8_x_none", 24'h020E00, 2'd1);
    send("R8_y_unknown", 24'h020E00, 2'd2);
    drain();

    // R11: new mode applies right after the write
    cfg_load(3'd1, 3'd1);
    send("R11_after_write", 24'h000400, 2'd1);
    send("R11_after_write_b9", 24'h000200, 2'd1);
    drain();

    // R10 stall hold
    @(negedge clk); rdy_force = 1'b0;
    send("R10_stalled_item", 24'h123640, 2'd1);
    @(negedge clk); #2;
    check("R10_valid_held", out_valid, 1);
    check("R9_ready_low_on_stall", in_ready, 0);
    held = out_addr;
    repeat (3) @(negedge clk);
    #2;
    check("R10_addr_held", out_addr, held);
    check("R10_valid_still", out_valid, 1);
    rdy_force = 1'b1;
    drain();

    // R9 throughput with random backpressure
    cfg_load(3'd4, 3'd5);
    bp_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = AW'(32'h9E3779B9 * (i + 1));
      send("R9_stream", a, 2'(i % 4));
    end
    drain();
    bp_en = 1'b0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule